// File: doc/BRIEF.md
# Multistage CIC Interpolation Filter

This block raises the sample rate of a signed stream by an integer factor without using any multipliers. A cascade of comb stages runs at the slow rate. Each comb stage subtracts a copy of its input delayed by a fixed number of slow samples. A zero-stuffer follows the combs: it passes the comb result in one slot of every group of `RATE` fast slots and zero in all other slots. A cascade of running-sum integrators then runs at the fast rate and turns the sparse stream into a smooth, upsampled one. Together, the combs and integrators act as an FIR filter with a rectangular window of length `RATE*DDLY`, applied `STAGES` times over.

The surrounding logic drives the fast rate by pulsing `step`, once per output slot. An internal phase counter marks the slot in which a new input is taken, and that slot is visible on `din_ready`. All arithmetic is two's complement at a full-precision width derived from the parameters. Intermediate integrator overflow therefore wraps and cancels, and the final output is exact.

Top module: `cic_interp`

## Requirements
- R1: A synchronous active-high `rst` clears the comb delay lines, the integrators and the phase counter. In the cycle after a reset edge, `dout` is 0, `dout_valid` is 0 and `din_ready` is 1.
- R2: `din_ready` is 1 exactly when the phase count is 0. Each `step` advances the phase by one, and after `RATE` steps it returns to 0. With the defaults (`RATE`=16), `din_ready` is high in one step slot out of 16.
- R3: `din` and `in_valid` are sampled only on a `step` edge while `din_ready` is 1. Their values at any other time have no effect on `dout`.
- R4: A phase-0 step with `in_valid` low feeds a zero sample into the comb section.
- R5: `dout_valid` is 1 in the cycle after each `step` edge and 0 otherwise. Without `step`, `dout` holds its value.
- R6: The output follows the model below. Let u[k] be the zero-stuffed input of step k counted since reset: the taken sample when k mod `RATE` = 0, and zero otherwise. Let h be the `STAGES`-fold convolution of a box of `RATE*DDLY` ones. The `dout` presented after step s is then (h*u)[s-`STAGES`+1].
- R7: A constant input x settles to x·(`RATE`·`DDLY`)^`STAGES`/`RATE`. With the defaults, that is x·256.
- R8: Full-scale and random inputs give an output equal to the model of R6, because internal overflow wraps in two's complement.
- R9: The width of `dout` is `DIN_W` + `STAGES`·ceil(log2(`RATE`·`DDLY`)). With the defaults, that is 28 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Fast-rate enable; one output slot per pulse |
| in_valid | input | 1 | `din` holds a real sample in the phase-0 slot |
| din | input | DIN_W | Signed input sample |
| din_ready | output | 1 | The current phase is 0, so the next step takes `din` |
| dout | output | ACC_W | Signed full-precision output sample |
| dout_valid | output | 1 | `dout` was updated on the last edge |

## Verification
The hardest situation to reach is a wraparound deep inside the integrator chain that must still cancel exactly at the output. This only happens when large inputs of alternating sign arrive back to back. The stimulus therefore drives full-scale values of opposite sign into consecutive phase-0 slots, followed by random full-scale data. A second hard case is an irregular `step` pattern in which `in_valid` is low in some phase-0 slots while garbage appears in other slots. A run with random step gaps and random valid/data covers both effects at once.

// File: rtl/cic_pkg.sv
`timescale 1ns/1ps
package cic_pkg;

  // bits of growth per stage for a rate/delay pair
  function automatic int unsigned cic_growth(input int unsigned rate, input int unsigned ddly);
    return $clog2(rate * ddly);
  endfunction

  // full-precision datapath width
  function automatic int unsigned cic_acc_width(input int unsigned din_w, input int unsigned stages,
                                                input int unsigned rate, input int unsigned ddly);
    return din_w + stages * cic_growth(rate, ddly);
  endfunction

endpackage

// File: rtl/cic_phase.sv
`timescale 1ns/1ps
module cic_phase #(
  parameter int unsigned RATE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic at_zero
);
  localparam int unsigned PH_W = (RATE > 1) ? $clog2(RATE) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(RATE - 1);

  logic [PH_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (adv)
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign at_zero = (cnt == '0);
endmodule

// File: rtl/cic_comb.sv
`timescale 1ns/1ps
module cic_comb #(
  parameter int unsigned W    = 28,
  parameter int unsigned DDLY = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] y
);
  // delay line at the slow rate
  logic signed [W-1:0] dly [DDLY];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DDLY; i++) dly[i] <= '0;
    end else if (en) begin
      dly[0] <= x;
      for (int i = 1; i < DDLY; i++) dly[i] <= dly[i-1];
    end
  end

  assign y = x - dly[DDLY-1];
endmodule

// File: rtl/cic_integ.sv
`timescale 1ns/1ps
module cic_integ #(
  parameter int unsigned W = 28
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)
      acc <= '0;
    else if (en)
      acc <= acc + x;   // wraps in two's complement
  end
endmodule

// File: rtl/cic_interp.sv
`timescale 1ns/1ps
module cic_interp
  import cic_pkg::*;
#(
  parameter int unsigned DIN_W  = 16,
  parameter int unsigned RATE   = 16,
  parameter int unsigned DDLY   = 1,
  parameter int unsigned STAGES = 3,
  localparam int unsigned ACC_W = cic_acc_width(DIN_W, STAGES, RATE, DDLY)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step,
  input  logic                    in_valid,
  input  logic signed [DIN_W-1:0] din,
  output logic                    din_ready,
  output logic signed [ACC_W-1:0] dout,
  output logic                    dout_valid
);
  logic phase0;
  logic take;

  cic_phase #(.RATE(RATE)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .adv    (step),
    .at_zero(phase0)
  );

  assign din_ready = phase0;
  assign take      = step & phase0;

  // comb section, slow rate
  logic signed [ACC_W-1:0] comb_v [STAGES+1];
  assign comb_v[0] = in_valid ? ACC_W'(din) : '0;

  for (genvar g = 0; g < STAGES; g++) begin : g_comb
    cic_comb #(.W(ACC_W), .DDLY(DDLY)) u_comb (
      .clk(clk),
      .rst(rst),
      .en (take),
      .x  (comb_v[g]),
      .y  (comb_v[g+1])
    );
  end

  // zero-stuffer then integrator section, fast rate
  logic signed [ACC_W-1:0] integ_v [STAGES+1];
  assign integ_v[0] = phase0 ? comb_v[STAGES] : '0;

  for (genvar g = 0; g < STAGES; g++) begin : g_integ
    cic_integ #(.W(ACC_W)) u_integ (
      .clk(clk),
      .rst(rst),
      .en (step),
      .x  (integ_v[g]),
      .acc(integ_v[g+1])
    );
  end

  assign dout = integ_v[STAGES];

  always_ff @(posedge clk) begin
    if (rst)
      dout_valid <= 1'b0;
    else
      dout_valid <= step;
  end
endmodule

// File: rtl/cic_interp_chk.sv
`timescale 1ns/1ps
module cic_interp_chk #(
  parameter int unsigned RATE  = 16,
  parameter int unsigned ACC_W = 28
) (
  input logic             clk,
  input logic             rst,
  input logic             step,
  input logic             din_ready,
  input logic [ACC_W-1:0] dout,
  input logic             dout_valid
);
  localparam int unsigned CW = (RATE > 1) ? $clog2(RATE) : 1;
  localparam logic [CW-1:0] CLAST = CW'(RATE - 1);

  logic [CW-1:0] slot;
  always_ff @(posedge clk) begin
    if (rst)
      slot <= '0;
    else if (step)
      slot <= (slot == CLAST) ? '0 : slot + 1'b1;
  end

  AST_READY_SLOT: assert property (@(posedge clk) disable iff (rst) din_ready == (slot == '0)); // R2
  AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (rst) step |=> dout_valid); // R5
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !step |=> !dout_valid); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !step |=> $stable(dout)); // R5
endmodule

bind cic_interp cic_interp_chk #(.RATE(RATE), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .step      (step),
  .din_ready (din_ready),
  .dout      (dout),
  .dout_valid(dout_valid)
);

// File: tb/test_cic_interp.sv
`timescale 1ns/1ps
module test_cic_interp;
  localparam int unsigned DIN_W  = 16;
  localparam int unsigned RATE   = 16;
  localparam int unsigned DDLY   = 1;
  localparam int unsigned STAGES = 3;
  localparam int unsigned ACC_W  = 28;
  localparam int unsigned RM     = RATE * DDLY;
  localparam int unsigned HL     = STAGES * (RM - 1) + 1;
  localparam int unsigned HMAX   = 4096;

  logic clk = 1'b0;
  logic rst, step, in_valid;
  logic signed [DIN_W-1:0] din;
  logic din_ready, dout_valid;
  logic signed [ACC_W-1:0] dout;

  always #2.5 clk = ~clk;

  cic_interp #(.DIN_W(DIN_W), .RATE(RATE), .DDLY(DDLY), .STAGES(STAGES)) i_cic_interp (
    .clk(clk), .rst(rst), .step(step), .in_valid(in_valid), .din(din),
    .din_ready(din_ready), .dout(dout), .dout_valid(dout_valid)
  );

  int checks = 0, errors = 0;
  int s = 0, ph = 0;
  longint ustore [HMAX];
  longint h [HL];
  longint expq [$];
  bit pushed = 0;
  string req = "R6";
  logic signed [ACC_W-1:0] prev_dout;

  task automatic check(input bit ok, input string r, input longint act, input longint exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic longint model_at(input int n);
    longint acc = 0;
    for (int k = 0; k < HL; k++)
      if (n - k >= 0) acc += h[k] * ustore[n-k];
    return acc;
  endfunction

  // driver: one clock slot, pushes the expected output of that slot
  task automatic drive(input bit st, input bit v, input logic signed [DIN_W-1:0] d);
    @(negedge clk);
    step = st; in_valid = v; din = d;
    @(posedge clk);
    if (st) begin
      ustore[s] = (ph == 0 && v) ? longint'(d) : 0;
      expq.push_back(model_at(s - int'(STAGES) + 1));
      s++;
      ph = (ph + 1) % RATE;
      pushed = 1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; step = 0; in_valid = 0; din = '0;
    @(posedge clk);
    s = 0; ph = 0; pushed = 0; expq.delete();
    for (int i = 0; i < HMAX; i++) ustore[i] = 0;
    #1;
    check(dout == '0, "R1", dout, 0, "dout after reset");
    check(dout_valid == 1'b0, "R1", dout_valid, 0, "dout_valid after reset");
    check(din_ready == 1'b1, "R1", din_ready, 1, "din_ready after reset");
    @(negedge clk);
    rst = 0;
  endtask

  // monitor / scoreboard
  always begin
    @(posedge clk);
    #1;
    if (rst) begin
      prev_dout = dout;
      pushed = 0;
    end else begin
      check(din_ready == (ph == 0), "R2", din_ready, (ph == 0), "din_ready vs phase");
      check(dout_valid == pushed, "R5", dout_valid, pushed, "dout_valid vs step");
      if (dout_valid) begin
        if (expq.size() == 0) begin
          check(1'b0, req, dout, 0, "unexpected output");
        end else begin
          longint e;
          logic signed [ACC_W-1:0] et;
          e = expq.pop_front();
          et = e[ACC_W-1:0];
          check(dout == et, req, dout, et, "output vs window model");
        end
      end else begin
        check(dout == prev_dout, "R5", dout, prev_dout, "dout held without step");
      end
      prev_dout = dout;
      pushed = 0;
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint tmp [HL];
    rst = 1; step = 0; in_valid = 0; din = '0;
    // build the repeated box window
    for (int n = 0; n < HL; n++) h[n] = (n < RM) ? 1 : 0;
    for (int st = 1; st < STAGES; st++) begin
      for (int n = 0; n < HL; n++) begin
        tmp[n] = 0;
        for (int k = 0; k < RM; k++) if (n - k >= 0) tmp[n] += h[n-k];
      end
      for (int n = 0; n < HL; n++) h[n] = tmp[n];
    end

    do_reset();
    check($bits(dout) == 28, "R9", $bits(dout), 28, "output width");

    // R6 impulse response
    req = "R6";
    drive(1, 1, 16'sd1000);
    for (int i = 0; i < 6 * RATE; i++) drive(1, 0, '0);
    drive(1, 1, -16'sd7);
    for (int i = 0; i < 5 * RATE; i++) drive(1, 0, '0);

    // R3 garbage in non-phase-0 slots and idle cycles
    req = "R3";
    for (int i = 0; i < 8 * RATE; i++) begin
      drive(1, 1, DIN_W'($urandom));
      drive(0, 1, DIN_W'($urandom));
    end

    // R4 valid low in some phase-0 slots
    req = "R4";
    for (int i = 0; i < 8 * RATE; i++) drive(1, (i / RATE) % 2 == 0, 16'sd300);

    // R5 random step gaps
    req = "R5";
    for (int i = 0; i < 400; i++) drive(($urandom % 3) != 0, $urandom % 2, DIN_W'($urandom));
    for (int i = 0; i < 4; i++) drive(0, 0, '0);

    // R7 DC gain after a mid-run reset
    do_reset();
    req = "R7";
    for (int i = 0; i < 12 * RATE; i++) drive(1, 1, 16'sd1234);
    #1;
    check(dout == ACC_W'(1234 * 256), "R7", dout, 1234 * 256, "DC level");
    for (int i = 0; i < 12 * RATE; i++) drive(1, 1, -16'sd5);
    #1;
    check(dout == ACC_W'(-5 * 256), "R7", dout, -5 * 256, "negative DC level");

    // R8 full-scale alternating then random
    req = "R8";
    for (int i = 0; i < 10 * RATE; i++)
      drive(1, 1, ((i / RATE) % 2 == 0) ? 16'sh7fff : 16'sh8000);
    for (int i = 0; i < 10 * RATE; i++) drive(1, 1, DIN_W'($urandom));
    for (int i = 0; i < 4 * RATE; i++) drive(1, 0, '0);
    for (int i = 0; i < 4; i++) drive(0, 0, '0);

    check(expq.size() == 0, "R5", expq.size(), 0, "scoreboard drained");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule